// File: doc/BRIEF.md
# Twisted-Pair Link and Collision Status Controller

This block tracks the link state of a twisted-pair attachment unit and turns the raw activity levels of the transmit and receive pairs into status flags. It starts in the link-fail state. From there it reaches link-pass either by counting a parameterized number of link beat pulses (five by default) or by seeing one received packet. A missing-pulse timer counts bit-time ticks while the link is up. When a whole window goes by with neither a beat nor a packet, the link drops back to fail.

While the link is up, the block reports transmit and receive activity. It flags a collision when both pairs are active together, and it holds that flag for two extra bit times after the overlap ends. It also chooses where the data-out path takes its data from: the receive pair, or a loopback of the transmit data. It drives the enable for the heartbeat (SQE) test, which is held off while the twisted-pair port is selected and its link has failed.

Reset, sleep, or deselecting the port clears all of the internal state and silences every status output. Re-selecting the port or waking from sleep therefore always restarts in link-fail with an empty pulse count.

Top module: `tp_link_status`

## Requirements
- R1: While `rst` is high, on each clock edge `link_pass`, `xmt`, `rcv`, `col`, `dout_from_rx` and `sqe_en` become 0. The link state becomes fail.
- R2: In fail, `link_pass` rises on the cycle after the edge that samples the PASS_PULSES-th `beat_stb` pulse (default 5). Fewer pulses leave it at 0.
- R3: In fail, a single `pkt_stb` pulse makes `link_pass` 1 on the next cycle, whatever the pulse count is.
- R4: In pass, `bit_tick` pulses are counted, and any `beat_stb` or `pkt_stb` clears the count. When TIMEOUT_TICKS ticks are counted, the link returns to fail on the cycle after the last tick, and the pulse count is cleared.
- R5: `xmt` and `rcv` equal `tx_act` and `rx_act` delayed by one cycle, but only when the link was in pass at that edge. Otherwise they are 0.
- R6: When the link is in pass and `rx_act` and `tx_act` are both 1 at an edge, `col` is 1 on the next cycle.
- R7: Once the overlap ends, `col` stays high until the edge that samples the second `bit_tick` after the end (HOLD_TICKS, default 2). It is 0 from the cycle after that edge. `col` is 0 whenever the link was in fail.
- R8: `dout_from_rx` is 1 (receive pair is the source) on any cycle where `col` is 1. With the link in pass, it is also 1 when `rx_act` was 1 at the edge. Otherwise it is 0 (transmit loopback).
- R9: `sqe_en` is 0 one cycle after an edge where `sel_tp`=1 and the link is in fail. It is 1 one cycle after an edge where `sel_tp`=0, or where the link is in pass and `sleep`=0.
- R10: `sel_tp`=0 or `sleep`=1 at an edge clears the link state, the pulse count and all activity outputs on the next cycle. After wake-up or re-selection, a full PASS_PULSES beats are again needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_tp | input | 1 | 1 = twisted-pair port selected, 0 = AUI selected |
| sleep | input | 1 | 1 = power-down request |
| beat_stb | input | 1 | One-cycle pulse per link beat pulse received |
| pkt_stb | input | 1 | One-cycle pulse per received packet |
| rx_act | input | 1 | Receive pair carries activity |
| tx_act | input | 1 | Transmit pair carries activity |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| link_pass | output | 1 | Link is in the pass state |
| xmt | output | 1 | Transmit activity status |
| rcv | output | 1 | Receive activity status |
| col | output | 1 | Collision status, stretched |
| sqe_en | output | 1 | Heartbeat test enable |
| dout_from_rx | output | 1 | 1 = data-out sourced from receive pair, 0 = transmit loopback |

## Verification
Every output of this block is a register. Each one therefore reflects the inputs sampled at one clock edge and the link state held at that same edge, so it is due exactly one cycle later. `link_pass` changes one cycle after the beat, packet or final timeout tick that triggers it. `sqe_en` and the activity flags use the link state from before that edge, so they follow `link_pass` one cycle later. The bench drives inputs on the falling edge and updates its reference model right after the rising edge from the same inputs. It compares all six outputs on the next falling edge, so every expected value is checked in the cycle it becomes due.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } link_state_e;

  // Width needed to hold values 0..n
  function automatic int unsigned span_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tp_link_fsm.sv
module tp_link_fsm
  import tp_link_pkg::*;
#(
  parameter int unsigned PASS_PULSES   = 5,
  parameter int unsigned TIMEOUT_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic beat_stb,
  input  logic pkt_stb,
  input  logic bit_tick,
  output logic link_up
);

  localparam int unsigned CW = span_bits(PASS_PULSES);
  localparam int unsigned TW = span_bits(TIMEOUT_TICKS);
  localparam logic [CW-1:0] BEAT_LAST = CW'(PASS_PULSES - 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_TICKS - 1);

  link_state_e   state_q, state_d;
  logic [CW-1:0] beats_q, beats_d;
  logic [TW-1:0] idle_q,  idle_d;

  always_comb begin
    state_d = state_q;
    beats_d = beats_q;
    idle_d  = idle_q;
    unique case (state_q)
      LNK_DOWN: begin
        idle_d = '0;
        if (pkt_stb) begin
          state_d = LNK_UP;
          beats_d = '0;
        end else if (beat_stb) begin
          if (beats_q == BEAT_LAST) begin
            state_d = LNK_UP;
            beats_d = '0;
          end else begin
            beats_d = beats_q + 1'b1;
          end
        end
      end
      LNK_UP: begin
        if (beat_stb || pkt_stb) begin
          idle_d = '0;
        end else if (bit_tick) begin
          if (idle_q == IDLE_LAST) begin
            state_d = LNK_DOWN;
            idle_d  = '0;
            beats_d = '0;
          end else begin
            idle_d = idle_q + 1'b1;
          end
        end
      end
      default: state_d = LNK_DOWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= LNK_DOWN;
      beats_q <= '0;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      beats_q <= beats_d;
      idle_q  <= idle_d;
    end
  end

  assign link_up = (state_q == LNK_UP);

endmodule

// File: rtl/tp_coll_stretch.sv
module tp_coll_stretch
  import tp_link_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic enable,
  input  logic rx_act,
  input  logic tx_act,
  input  logic bit_tick,
  output logic coll_d,
  output logic coll_q
);

  localparam int unsigned HW = span_bits(HOLD_TICKS);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_TICKS);

  logic [HW-1:0] hold_q, hold_d;
  logic          overlap;

  assign overlap = rx_act && tx_act;

  always_comb begin
    coll_d = coll_q;
    hold_d = hold_q;
    if (!enable) begin
      coll_d = 1'b0;
      hold_d = '0;
    end else if (overlap) begin
      coll_d = 1'b1;
      hold_d = HOLD_INIT;
    end else if (coll_q && bit_tick) begin
      if (hold_q <= HW'(1)) begin
        coll_d = 1'b0;
        hold_d = '0;
      end else begin
        hold_d = hold_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      coll_q <= 1'b0;
      hold_q <= '0;
    end else begin
      coll_q <= coll_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/tp_link_status.sv
module tp_link_status
  import tp_link_pkg::*;
#(
  parameter int unsigned PASS_PULSES   = 5,
  parameter int unsigned TIMEOUT_TICKS = 1000,
  parameter int unsigned HOLD_TICKS    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_tp,
  input  logic sleep,
  input  logic beat_stb,
  input  logic pkt_stb,
  input  logic rx_act,
  input  logic tx_act,
  input  logic bit_tick,
  output logic link_pass,
  output logic xmt,
  output logic rcv,
  output logic col,
  output logic sqe_en,
  output logic dout_from_rx
);

  logic pwr_dn;
  logic link_up;
  logic coll_d;
  logic coll_q;
  logic xmt_q, rcv_q, dsel_q, sqe_q;

  assign pwr_dn = !sel_tp || sleep;

  tp_link_fsm #(
    .PASS_PULSES  (PASS_PULSES),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .clr     (pwr_dn),
    .beat_stb(beat_stb),
    .pkt_stb (pkt_stb),
    .bit_tick(bit_tick),
    .link_up (link_up)
  );

  tp_coll_stretch #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_coll (
    .clk     (clk),
    .rst     (rst),
    .clr     (pwr_dn),
    .enable  (link_up),
    .rx_act  (rx_act),
    .tx_act  (tx_act),
    .bit_tick(bit_tick),
    .coll_d  (coll_d),
    .coll_q  (coll_q)
  );

  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      xmt_q  <= 1'b0;
      rcv_q  <= 1'b0;
      dsel_q <= 1'b0;
    end else begin
      xmt_q  <= link_up && tx_act;
      rcv_q  <= link_up && rx_act;
      dsel_q <= link_up && (rx_act || coll_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sqe_q <= 1'b0;
    end else begin
      sqe_q <= !sel_tp || (!sleep && link_up);
    end
  end

  assign link_pass    = link_up;
  assign xmt          = xmt_q;
  assign rcv          = rcv_q;
  assign col          = coll_q;
  assign sqe_en       = sqe_q;
  assign dout_from_rx = dsel_q;

endmodule

// File: rtl/tp_link_status_chk.sv
module tp_link_status_chk (
  input logic clk,
  input logic rst,
  input logic sel_tp,
  input logic sleep,
  input logic beat_stb,
  input logic pkt_stb,
  input logic rx_act,
  input logic tx_act,
  input logic bit_tick,
  input logic link_pass,
  input logic xmt,
  input logic rcv,
  input logic col,
  input logic sqe_en,
  input logic dout_from_rx
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!link_pass && !xmt && !rcv && !col && !sqe_en && !dout_from_rx));

  assert_pass_needs_event_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(link_pass) |-> $past(beat_stb || pkt_stb));

  assert_fail_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !link_pass |=> (!xmt && !rcv && !col));

  assert_overlap_sets_col_R6: assert property (@(posedge clk) disable iff (rst)
    (link_pass && sel_tp && !sleep && rx_act && tx_act) |=> col);

  assert_col_held_R7: assert property (@(posedge clk) disable iff (rst)
    (col && link_pass && sel_tp && !sleep && !bit_tick) |=> col);

  assert_col_uses_rx_R8: assert property (@(posedge clk) disable iff (rst)
    col |-> dout_from_rx);

  assert_sqe_off_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_tp && !link_pass) |=> !sqe_en);

  assert_powerdown_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel_tp || sleep) |=> (!link_pass && !xmt && !rcv && !col && !dout_from_rx));

endmodule

bind tp_link_status tp_link_status_chk u_chk (.*);

// File: tb/test_tp_link_status.sv
module test_tp_link_status;

  localparam int P = 5;
  localparam int T = 24;
  localparam int H = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, sel_tp = 1'b0, sleep = 1'b0;
  logic beat_stb = 1'b0, pkt_stb = 1'b0, rx_act = 1'b0, tx_act = 1'b0, bit_tick = 1'b0;
  logic link_pass, xmt, rcv, col, sqe_en, dout_from_rx;

  tp_link_status #(
    .PASS_PULSES(P), .TIMEOUT_TICKS(T), .HOLD_TICKS(H)
  ) i_tp_link_status (
    .clk(clk), .rst(rst), .sel_tp(sel_tp), .sleep(sleep),
    .beat_stb(beat_stb), .pkt_stb(pkt_stb), .rx_act(rx_act), .tx_act(tx_act),
    .bit_tick(bit_tick), .link_pass(link_pass), .xmt(xmt), .rcv(rcv),
    .col(col), .sqe_en(sqe_en), .dout_from_rx(dout_from_rx)
  );

  int n_cmp = 0, n_bad = 0, cyc_no = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  bit m_link = 0, m_col = 0, m_xmt = 0, m_rcv = 0, m_dout = 0, m_sqe = 0;
  int m_beats = 0, m_idle = 0, m_hold = 0;

  task automatic model_edge();
    bit pd, nl, nc;
    pd = rst || !sel_tp || sleep;
    m_sqe = !rst && (!sel_tp || (!sleep && m_link));
    if (pd) begin
      m_link = 0; m_col = 0; m_xmt = 0; m_rcv = 0; m_dout = 0;
      m_beats = 0; m_idle = 0; m_hold = 0;
    end else begin
      nc = m_col;
      if (!m_link) begin nc = 0; m_hold = 0; end
      else if (rx_act && tx_act) begin nc = 1; m_hold = H; end
      else if (m_col && bit_tick) begin
        if (m_hold <= 1) begin nc = 0; m_hold = 0; end
        else m_hold--;
      end
      m_xmt  = m_link && tx_act;
      m_rcv  = m_link && rx_act;
      m_dout = m_link && (rx_act || nc);
      nl = m_link;
      if (!m_link) begin
        if (pkt_stb) begin nl = 1; m_beats = 0; end
        else if (beat_stb) begin
          if (m_beats + 1 >= P) begin nl = 1; m_beats = 0; end
          else m_beats++;
        end
      end else begin
        if (beat_stb || pkt_stb) m_idle = 0;
        else if (bit_tick) begin
          if (m_idle == T - 1) begin nl = 0; m_idle = 0; m_beats = 0; end
          else m_idle++;
        end
      end
      m_link = nl;
      m_col  = nc;
    end
  endtask

  task automatic chk(input string what, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", phase, what, act, exp, cyc_no);
    end
  endtask

  task automatic step();
    bit_tick = (cyc_no % 5 == 4);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("link_pass", link_pass, m_link);
    chk("xmt", xmt, m_xmt);
    chk("rcv", rcv, m_rcv);
    chk("col", col, m_col);
    chk("sqe_en", sqe_en, m_sqe);
    chk("dout_from_rx", dout_from_rx, m_dout);
    cyc_no++;
    beat_stb = 1'b0;
    pkt_stb  = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_stb = 1'b1; step();
      run(2);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    phase = "R1"; run(3);
    rst = 1'b0; sel_tp = 1'b1; run(2);
    // R2: four beats stay in fail, fifth passes
    phase = "R2"; beats(P - 1); run(3); beats(1); run(3);
    // R5 activity flags
    phase = "R5"; tx_act = 1'b1; run(4); tx_act = 1'b0; rx_act = 1'b1; run(4);
    // R6/R8 overlap, R7 stretch after tx ends
    phase = "R6"; tx_act = 1'b1; run(4);
    phase = "R7"; tx_act = 1'b0; run(14);
    phase = "R8"; rx_act = 1'b0; run(3);
    // stretch after rx ends, tx keeps going (loopback source after)
    phase = "R7"; rx_act = 1'b1; tx_act = 1'b1; run(3); rx_act = 1'b0; run(14);
    tx_act = 1'b0; run(2);
    // R4 keep-alive then timeout
    phase = "R4"; run(60); beats(1); run(T * 5 + 10);
    // R3 partial beats then packet
    phase = "R3"; beats(3); pkt_stb = 1'b1; step(); run(4);
    // R10 sleep clears, needs full count again
    phase = "R10"; rx_act = 1'b1; tx_act = 1'b1; run(2);
    sleep = 1'b1; run(4); rx_act = 1'b0; tx_act = 1'b0; sleep = 1'b0; run(2);
    beats(P - 1); run(3); beats(1); run(3);
    // R9 deselection: sqe enabled, link dropped
    phase = "R9"; sel_tp = 1'b0; beat_stb = 1'b1; run(5);
    sel_tp = 1'b1; run(3); pkt_stb = 1'b1; step(); run(4);
    // R1 reset in pass
    phase = "R1"; rx_act = 1'b1; tx_act = 1'b1; run(2); rst = 1'b1; run(3);
    rst = 1'b0; rx_act = 1'b0; tx_act = 1'b0; run(4);
    summary();
    $finish;
  end

endmodule